// File: doc/BRIEF.md
# Segment-Partitioned Associative Lookup Array

This block is a small content-addressable store. Each entry is one wide word plus a two-bit kind code. A global setting divides every word into a searched part and a payload part on fixed segment boundaries. The searched part always starts at the lowest segment. A search register, the comparand, is matched in parallel against the searched part of every entry of one chosen kind. An optional global bit mask can exclude single bits from the search.

Results are registered. They give a hit flag, a flag for more than one hit, and the lowest hitting address. A separate combinational output gives the lowest entry whose kind is empty. Writes and reads can address an entry directly, the last search winner, or the lowest empty entry. This lets a caller look up a key, update the payload stored next to it, or insert a new key in one command. The comparand can also be rotated one bit at a time in either direction. Commands arrive one per clock on a flat command port.

Top module: `segcam_array`

## Requirements
- R1: While reset is held and right after it ends, every entry has kind empty and data zero. The hit flag and the multi-hit flag are 0, the hit address and the comparand are 0, and the read outputs are data 0 and kind empty. The free flag is 1 and the free address is 0.
- R2: The kind code is {skip, empty}: 2'b00 valid, 2'b01 empty, 2'b10 skip, 2'b11 payload-only. A write stores `cmdType` as the entry's kind. Writing kind 2'b01 releases the entry, so it can be found as free.
- R3: With `camSegs` = k, only bits [16*(k+1)-1:0] take part in a compare. Bits above that range never affect the result.
- R4: When `maskEn` is 1, any bit set in `maskVal` is left out of the compare. When `maskEn` is 0, `maskVal` has no effect.
- R5: Opcode 1 (load-compare) loads `cmdData` into the comparand. It then compares that new value against entries of kind valid only. The results appear after the same clock edge that samples the command.
- R6: Opcode 2 (compare) compares the current comparand against entries whose kind equals `cmdType`. Its results appear after the sampling edge.
- R7: The hit address is the lowest address that matches. The multi-hit flag is 1 only when two or more entries match. When nothing matches, both flags are 0 and the hit address is 0.
- R8: The hit flag, the multi-hit flag and the hit address change only on opcodes 1 and 2.
- R9: Opcode 3 (write) selects its target with `cmdMode`. Mode 0 or 3 uses `cmdAddr`. Mode 1 uses the registered hit address and is dropped when the hit flag is 0. Mode 2 uses the free address and is dropped when the free flag is 0.
- R10: Opcode 4 (read) uses the same address modes as a write. It puts the entry's data and kind on `rdData` and `rdType` after the sampling edge. A dropped read, or any other command, leaves both outputs unchanged.
- R11: Opcode 5 rotates the comparand left by one bit, with the MSB moving into the LSB. Opcode 6 rotates it right by one bit. Opcodes 0 and 7 do nothing.
- R12: The free flag and free address show the lowest entry of kind empty. They follow a write in the same cycle after that write's sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Opcode |
| cmdMode | input | 2 | Address mode for write and read |
| cmdAddr | input | AW (3) | Direct address |
| cmdData | input | WIDTH (64) | Write data or comparand load value |
| cmdType | input | 2 | Kind to write, or kind to search |
| camSegs | input | 2 | Number of searched segments minus one |
| maskEn | input | 1 | Enable global compare mask |
| maskVal | input | WIDTH (64) | Mask, 1 = bit excluded |
| matchFlag | output | 1 | Last compare found a match |
| multiFlag | output | 1 | Last compare found two or more matches |
| matchAddr | output | AW (3) | Lowest matching address |
| freeFlag | output | 1 | At least one empty entry exists |
| freeAddr | output | AW (3) | Lowest empty address |
| rdData | output | WIDTH (64) | Data from the last read |
| rdType | output | 2 | Kind from the last read |
| cmpOut | output | WIDTH (64) | Current comparand |

## Verification
Compare results, read results and comparand rotations are all due one edge after the edge that samples the command. Free-address changes follow a write's sampling edge in the same way, because the free logic decodes the stored kinds directly. The bench drives each command on a falling edge, so the next rising edge samples it. A behavioural model updates on that rising edge, and every output is compared with the model on the following falling edge. The directed checks sample at that same falling edge. Drop cases, with no hit or no free entry, are observed through later reads of the entries they could have changed.

// File: rtl/segcam_pkg.sv
package segcam_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_LOADCMP = 3'd1,
    OP_COMPARE = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4,
    OP_ROTL    = 3'd5,
    OP_ROTR    = 3'd6,
    OP_SPARE   = 3'd7
  } camOp_e;

  typedef enum logic [1:0] {
    AM_ABS     = 2'd0,
    AM_HIT     = 2'd1,
    AM_FREE    = 2'd2,
    AM_ABS_ALT = 2'd3
  } addrMode_e;

  // kind code {skip, empty}
  localparam logic [1:0] KIND_VALID = 2'b00;
  localparam logic [1:0] KIND_EMPTY = 2'b01;
  localparam logic [1:0] KIND_SKIP  = 2'b10;
  localparam logic [1:0] KIND_RAM   = 2'b11;

  typedef struct packed {
    logic       cmpLoad;
    logic       cmpRun;
    logic       wrEn;
    logic       rdEn;
    logic       rotL;
    logic       rotR;
    logic [1:0] target;
  } camStrobe_t;

endpackage

// File: rtl/segcam_prio.sv
module segcam_prio #(
  parameter int N = 8,
  localparam int AW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [AW-1:0] idx
);

  assign any = |req;

  // lowest set position wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = AW'(i);
    end
  end

endmodule

// File: rtl/segcam_ctrl.sv
module segcam_ctrl
  import segcam_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic          cmdValid,
  input  logic [2:0]    cmdOp,
  input  logic [1:0]    cmdMode,
  input  logic [AW-1:0] cmdAddr,
  input  logic [1:0]    cmdType,
  input  logic          matchFlag,
  input  logic [AW-1:0] matchAddr,
  input  logic          freeFlag,
  input  logic [AW-1:0] freeAddr,
  output camStrobe_t    strobe,
  output logic [AW-1:0] accessAddr
);

  logic addrOk;

  always_comb begin
    case (addrMode_e'(cmdMode))
      AM_HIT: begin
        accessAddr = matchAddr;
        addrOk     = matchFlag;
      end
      AM_FREE: begin
        accessAddr = freeAddr;
        addrOk     = freeFlag;
      end
      default: begin
        accessAddr = cmdAddr;
        addrOk     = 1'b1;
      end
    endcase
  end

  always_comb begin
    strobe        = '0;
    strobe.target = cmdType;
    if (cmdValid) begin
      case (camOp_e'(cmdOp))
        OP_LOADCMP: begin
          strobe.cmpLoad = 1'b1;
          strobe.target  = KIND_VALID;
        end
        OP_COMPARE: strobe.cmpRun = 1'b1;
        OP_WRITE:   strobe.wrEn   = addrOk;
        OP_READ:    strobe.rdEn   = addrOk;
        OP_ROTL:    strobe.rotL   = 1'b1;
        OP_ROTR:    strobe.rotR   = 1'b1;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/segcam_datapath.sv
module segcam_datapath
  import segcam_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 64,
  parameter int SEG_W   = 16,
  localparam int AW     = $clog2(ENTRIES),
  localparam int NSEG   = WIDTH / SEG_W,
  localparam int SEL_W  = $clog2(NSEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  camStrobe_t       strobe,
  input  logic [AW-1:0]    accessAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [1:0]       wrType,
  input  logic [SEL_W-1:0] camSegs,
  input  logic             maskEn,
  input  logic [WIDTH-1:0] maskVal,
  output logic             matchFlag,
  output logic             multiFlag,
  output logic [AW-1:0]    matchAddr,
  output logic             freeFlag,
  output logic [AW-1:0]    freeAddr,
  output logic [WIDTH-1:0] rdData,
  output logic [1:0]       rdType,
  output logic [WIDTH-1:0] cmpOut
);

  logic [WIDTH-1:0] mem  [ENTRIES];
  logic [1:0]       kind [ENTRIES];
  logic [WIDTH-1:0] cmpReg;
  logic [WIDTH-1:0] careMask;
  logic [WIDTH-1:0] compVal;
  logic [ENTRIES-1:0] hitVec;
  logic [ENTRIES-1:0] freeVec;
  logic             hitAny;
  logic [AW-1:0]    hitIdx;

  // per-segment care bits: searched segment and not masked
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign careMask[s*SEG_W +: SEG_W] =
      (s <= int'(camSegs)) ? ~(maskEn ? maskVal[s*SEG_W +: SEG_W] : '0) : '0;
  end

  assign compVal = strobe.cmpLoad ? wrData : cmpReg;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    assign hitVec[e]  = (kind[e] == strobe.target) &&
                        (((mem[e] ^ compVal) & careMask) == '0);
    assign freeVec[e] = (kind[e] == KIND_EMPTY);
  end

  segcam_prio #(.N(ENTRIES)) u_hitPrio (
    .req (hitVec),
    .any (hitAny),
    .idx (hitIdx)
  );

  segcam_prio #(.N(ENTRIES)) u_freePrio (
    .req (freeVec),
    .any (freeFlag),
    .idx (freeAddr)
  );

  // storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        mem[i]  <= '0;
        kind[i] <= KIND_EMPTY;
      end
    end else if (strobe.wrEn) begin
      mem[accessAddr]  <= wrData;
      kind[accessAddr] <= wrType;
    end
  end

  // comparand
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpReg <= '0;
    end else if (strobe.cmpLoad) begin
      cmpReg <= wrData;
    end else if (strobe.rotL) begin
      cmpReg <= {cmpReg[WIDTH-2:0], cmpReg[WIDTH-1]};
    end else if (strobe.rotR) begin
      cmpReg <= {cmpReg[0], cmpReg[WIDTH-1:1]};
    end
  end

  // compare results
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      matchFlag <= 1'b0;
      multiFlag <= 1'b0;
      matchAddr <= '0;
    end else if (strobe.cmpLoad || strobe.cmpRun) begin
      matchFlag <= hitAny;
      multiFlag <= (hitVec & (hitVec - 1'b1)) != '0;
      matchAddr <= hitIdx;
    end
  end

  // read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData <= '0;
      rdType <= KIND_EMPTY;
    end else if (strobe.rdEn) begin
      rdData <= mem[accessAddr];
      rdType <= kind[accessAddr];
    end
  end

  assign cmpOut = cmpReg;

endmodule

// File: rtl/segcam_array.sv
module segcam_array
  import segcam_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 64,
  parameter int SEG_W   = 16,
  localparam int AW     = $clog2(ENTRIES),
  localparam int NSEG   = WIDTH / SEG_W,
  localparam int SEL_W  = $clog2(NSEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [1:0]       cmdMode,
  input  logic [AW-1:0]    cmdAddr,
  input  logic [WIDTH-1:0] cmdData,
  input  logic [1:0]       cmdType,
  input  logic [SEL_W-1:0] camSegs,
  input  logic             maskEn,
  input  logic [WIDTH-1:0] maskVal,
  output logic             matchFlag,
  output logic             multiFlag,
  output logic [AW-1:0]    matchAddr,
  output logic             freeFlag,
  output logic [AW-1:0]    freeAddr,
  output logic [WIDTH-1:0] rdData,
  output logic [1:0]       rdType,
  output logic [WIDTH-1:0] cmpOut
);

  camStrobe_t    strobe;
  logic [AW-1:0] accessAddr;

  segcam_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .cmdMode    (cmdMode),
    .cmdAddr    (cmdAddr),
    .cmdType    (cmdType),
    .matchFlag  (matchFlag),
    .matchAddr  (matchAddr),
    .freeFlag   (freeFlag),
    .freeAddr   (freeAddr),
    .strobe     (strobe),
    .accessAddr (accessAddr)
  );

  segcam_datapath #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .SEG_W(SEG_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .accessAddr (accessAddr),
    .wrData     (cmdData),
    .wrType     (cmdType),
    .camSegs    (camSegs),
    .maskEn     (maskEn),
    .maskVal    (maskVal),
    .matchFlag  (matchFlag),
    .multiFlag  (multiFlag),
    .matchAddr  (matchAddr),
    .freeFlag   (freeFlag),
    .freeAddr   (freeAddr),
    .rdData     (rdData),
    .rdType     (rdType),
    .cmpOut     (cmpOut)
  );

endmodule

// File: rtl/segcam_chk.sv
module segcam_chk #(
  parameter int WIDTH = 64,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmdValid,
  input logic [2:0]       cmdOp,
  input logic             matchFlag,
  input logic             multiFlag,
  input logic [AW-1:0]    matchAddr,
  input logic [WIDTH-1:0] rdData,
  input logic [1:0]       rdType,
  input logic [WIDTH-1:0] cmpOut
);

  // R7
  multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    multiFlag |-> matchFlag);

  // R8
  hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmdValid && (cmdOp == 3'd1 || cmdOp == 3'd2)) |=>
      ($stable(matchFlag) && $stable(multiFlag) && $stable(matchAddr)));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmdValid && cmdOp == 3'd4) |=> ($stable(rdData) && $stable(rdType)));

  // R11
  rot_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdOp == 3'd5) |=>
      cmpOut == {$past(cmpOut[WIDTH-2:0]), $past(cmpOut[WIDTH-1])});

  // R11
  rot_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdOp == 3'd6) |=>
      cmpOut == {$past(cmpOut[0]), $past(cmpOut[WIDTH-1:1])});

endmodule

bind segcam_array segcam_chk #(.WIDTH(WIDTH), .AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmdValid  (cmdValid),
  .cmdOp     (cmdOp),
  .matchFlag (matchFlag),
  .multiFlag (multiFlag),
  .matchAddr (matchAddr),
  .rdData    (rdData),
  .rdType    (rdType),
  .cmpOut    (cmpOut)
);

// File: tb/segcam_array_tb.sv
module segcam_array_tb_top;

  localparam int N = 8;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmdValid = 1'b0;
  logic [2:0]   cmdOp = '0;
  logic [1:0]   cmdMode = '0;
  logic [2:0]   cmdAddr = '0;
  logic [W-1:0] cmdData = '0;
  logic [1:0]   cmdType = '0;
  logic [1:0]   camSegs = 2'd3;
  logic         maskEn = 1'b0;
  logic [W-1:0] maskVal = '0;
  logic         matchFlag, multiFlag, freeFlag;
  logic [2:0]   matchAddr, freeAddr;
  logic [W-1:0] rdData, cmpOut;
  logic [1:0]   rdType;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  segcam_array dut_i (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdMode(cmdMode), .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdType(cmdType),
    .camSegs(camSegs), .maskEn(maskEn), .maskVal(maskVal),
    .matchFlag(matchFlag), .multiFlag(multiFlag), .matchAddr(matchAddr),
    .freeFlag(freeFlag), .freeAddr(freeAddr), .rdData(rdData),
    .rdType(rdType), .cmpOut(cmpOut)
  );

  // ---------------- reference model ----------------
  logic [W-1:0] mData [N];
  logic [1:0]   mKind [N];
  logic [W-1:0] mCmp, mRd;
  logic [1:0]   mRdT;
  bit           mHit, mMulti;
  int           mHitA;

  function automatic int lowestFree();
    for (int i = 0; i < N; i++) if (mKind[i] == 2'b01) return i;
    return -1;
  endfunction

  function automatic int resolve(input logic [1:0] mode, input logic [2:0] a);
    if (mode == 2'd1) return mHit ? mHitA : -1;
    if (mode == 2'd2) return lowestFree();
    return int'(a);
  endfunction

  task automatic modelCompare(input logic [W-1:0] key, input logic [1:0] tgt);
    int cnt = 0;
    int first = -1;
    for (int i = 0; i < N; i++) begin
      bit same = 1'b1;
      for (int b = 0; b < W; b++) begin
        bit used = (b < 16 * (int'(camSegs) + 1)) && !(maskEn && maskVal[b]);
        if (used && mData[i][b] != key[b]) same = 1'b0;
      end
      if (same && mKind[i] == tgt) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
    mHit   = cnt > 0;
    mMulti = cnt > 1;
    mHitA  = (first < 0) ? 0 : first;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        mData[i] = '0;
        mKind[i] = 2'b01;
      end
      mCmp = '0; mRd = '0; mRdT = 2'b01;
      mHit = 1'b0; mMulti = 1'b0; mHitA = 0;
    end else if (cmdValid) begin
      int t;
      case (cmdOp)
        3'd1: begin mCmp = cmdData; modelCompare(mCmp, 2'b00); end
        3'd2: modelCompare(mCmp, cmdType);
        3'd3: begin
          t = resolve(cmdMode, cmdAddr);
          if (t >= 0) begin mData[t] = cmdData; mKind[t] = cmdType; end
        end
        3'd4: begin
          t = resolve(cmdMode, cmdAddr);
          if (t >= 0) begin mRd = mData[t]; mRdT = mKind[t]; end
        end
        3'd5: mCmp = {mCmp[W-2:0], mCmp[W-1]};
        3'd6: mCmp = {mCmp[0], mCmp[W-1:1]};
        default: ;
      endcase
    end
  end

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int fa;
      fa = lowestFree();
      check("R7",  "matchFlag", W'(matchFlag), W'(mHit));
      check("R7",  "multiFlag", W'(multiFlag), W'(mMulti));
      check("R7",  "matchAddr", W'(matchAddr), W'(mHitA));
      check("R12", "freeFlag",  W'(freeFlag),  W'(fa >= 0));
      check("R12", "freeAddr",  W'(freeAddr),  W'((fa < 0) ? 0 : fa));
      check("R10", "rdData",    rdData,        mRd);
      check("R10", "rdType",    W'(rdType),    W'(mRdT));
      check("R11", "cmpOut",    cmpOut,        mCmp);
    end
  end

  // drive at a falling edge, return at the next falling edge
  task automatic issue(input logic [2:0] op, input logic [1:0] mode,
                       input logic [2:0] a, input logic [W-1:0] d,
                       input logic [1:0] ty);
    cmdValid = 1'b1; cmdOp = op; cmdMode = mode;
    cmdAddr = a; cmdData = d; cmdType = ty;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  localparam logic [W-1:0] KA = 64'h1111_2222_3333_4444;
  localparam logic [W-1:0] KB = 64'h9999_2222_3333_4444;
  localparam logic [W-1:0] KC = 64'hC0C0_0000_0000_00C0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "freeFlag",  W'(freeFlag),  W'(1));
    check("R1", "freeAddr",  W'(freeAddr),  W'(0));
    check("R1", "matchFlag", W'(matchFlag), W'(0));
    check("R1", "cmpOut",    cmpOut,        '0);
    check("R1", "rdType",    W'(rdType),    W'(2'b01));

    issue(3'd3, 2'd0, 3'd0, KA, 2'b00);
    issue(3'd3, 2'd0, 3'd1, KA, 2'b10);
    issue(3'd3, 2'd0, 3'd2, KA, 2'b11);
    issue(3'd3, 2'd0, 3'd3, KB, 2'b00);
    check("R12", "freeAddr after fill", W'(freeAddr), W'(4));

    // R3: only the lowest segment searched
    camSegs = 2'd0;
    issue(3'd1, 2'd0, 3'd0, KA, 2'b00);
    check("R5", "hit on load-compare", W'(matchFlag), W'(1));
    check("R7", "multi with two valid", W'(multiFlag), W'(1));
    check("R7", "lowest address", W'(matchAddr), W'(0));
    // R3: three segments, top segment is payload and ignored
    camSegs = 2'd2;
    issue(3'd1, 2'd0, 3'd0, KA, 2'b00);
    check("R3", "payload ignored", W'(multiFlag), W'(1));
    camSegs = 2'd3;
    issue(3'd1, 2'd0, 3'd0, KA, 2'b00);
    check("R3", "full width single", W'(multiFlag), W'(0));
    check("R3", "full width addr", W'(matchAddr), W'(0));
    // R6: compare against skip and payload-only kinds
    issue(3'd2, 2'd0, 3'd0, '0, 2'b10);
    check("R6", "skip kind addr", W'(matchAddr), W'(1));
    issue(3'd2, 2'd0, 3'd0, '0, 2'b11);
    check("R6", "ram kind addr", W'(matchAddr), W'(2));
    // R4: mask top segment
    maskEn = 1'b1; maskVal = 64'hFFFF_0000_0000_0000;
    issue(3'd1, 2'd0, 3'd0, KA, 2'b00);
    check("R4", "masked multi", W'(multiFlag), W'(1));
    maskEn = 1'b0;
    // R8: write does not touch flags
    issue(3'd3, 2'd0, 3'd5, 64'h55, 2'b00);
    check("R8", "flags kept", W'({matchFlag, multiFlag, matchAddr}), W'({1'b1, 1'b1, 3'd0}));
    // R9: write to the hit entry, then read it back
    issue(3'd3, 2'd1, 3'd7, KC, 2'b00);
    issue(3'd4, 2'd0, 3'd0, '0, 2'b00);
    check("R9", "hit write data", rdData, KC);
    check("R10", "read kind", W'(rdType), W'(2'b00));
    // R9: free writes fill 4, 6, 7
    issue(3'd3, 2'd2, 3'd0, 64'hA4, 2'b00);
    issue(3'd3, 2'd2, 3'd0, 64'hA6, 2'b00);
    issue(3'd3, 2'd2, 3'd0, 64'hA7, 2'b00);
    check("R12", "full", W'(freeFlag), W'(0));
    issue(3'd3, 2'd2, 3'd0, 64'hDD, 2'b00);
    issue(3'd4, 2'd0, 3'd7, '0, 2'b00);
    check("R9", "dropped free write", rdData, 64'hA7);
    // R2: empty kind releases the entry; skip kind reads back
    issue(3'd3, 2'd0, 3'd6, 64'h0, 2'b01);
    check("R2", "released entry", W'(freeAddr), W'(6));
    issue(3'd4, 2'd0, 3'd1, '0, 2'b00);
    check("R2", "skip kind code", W'(rdType), W'(2'b10));
    // R9/R10: no hit drops write and read
    issue(3'd1, 2'd0, 3'd0, 64'hDEAD_BEEF_0000_0001, 2'b00);
    check("R5", "no hit", W'(matchFlag), W'(0));
    issue(3'd3, 2'd1, 3'd0, 64'hFF, 2'b00);
    issue(3'd4, 2'd0, 3'd0, '0, 2'b00);
    check("R9", "no-hit write dropped", rdData, KC);
    issue(3'd4, 2'd0, 3'd2, '0, 2'b00);
    issue(3'd4, 2'd1, 3'd0, '0, 2'b00);
    check("R10", "no-hit read holds", rdData, KA);
    // R11 rotation
    issue(3'd1, 2'd0, 3'd0, 64'h8000_0000_0000_0001, 2'b00);
    issue(3'd5, 2'd0, 3'd0, '0, 2'b00);
    check("R11", "rotate left", cmpOut, 64'h0000_0000_0000_0003);
    issue(3'd6, 2'd0, 3'd0, '0, 2'b00);
    issue(3'd6, 2'd0, 3'd0, '0, 2'b00);
    check("R11", "rotate right", cmpOut, 64'hC000_0000_0000_0000);
    issue(3'd7, 2'd0, 3'd0, 64'h1, 2'b00);
    check("R11", "spare opcode idle", cmpOut, 64'hC000_0000_0000_0000);

    // random traffic, checked every cycle against the model
    for (int k = 0; k < 600; k++) begin
      logic [W-1:0] d;
      logic [W-1:0] pool [4];
      pool[0] = KA; pool[1] = KB; pool[2] = KC; pool[3] = 64'h0;
      d = pool[$urandom_range(3)];
      if ($urandom_range(3) == 0) d[$urandom_range(63)] ^= 1'b1;
      camSegs = 2'($urandom_range(3));
      maskEn  = 1'($urandom_range(1));
      maskVal = {$urandom, $urandom} & {$urandom, $urandom};
      issue(3'($urandom_range(7)), 2'($urandom_range(3)), 3'($urandom_range(7)),
            d, 2'($urandom_range(3)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule